// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block runs complete serial-flash transactions in hardware on top of a bare one-byte SPI exchange engine. Software, or any other client, hands it one request made of an operation, a 24-bit address and a byte count. The sequencer then asserts chip select through the engine and sends the command byte. For a data read it also sends the address. It then clocks out one 0x00 filler byte for every byte to be read, returns the wanted responses on a byte stream, releases chip select and pulses `done`.

The engine exposes a select-enable write (`eng_enable` qualified by `eng_enable_vld`), a transmit-byte load (`eng_tx_data` with `eng_tx_vld`), a `eng_start` pulse, a `eng_ready` level and the last received byte `eng_rx_data`. For every byte the sequencer follows a fixed order: load the byte, wait for ready, pulse start, wait for ready again, then capture the response.

The received-byte stream follows valid/ready rules. `out_valid` stays high and `out_data` stays unchanged until `out_ready` is seen high at a clock edge. While a byte waits at the output, the sequencer does not start the engine on the next filler byte, so a slow consumer stalls the flash clock and no data is dropped. Requests use `req_valid`/`req_ready`. `req_ready` is high only while the sequencer is idle.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `out_valid`, `done`, `err`, `eng_enable_vld`, `eng_tx_vld` and `eng_start` are all 0.
- R2: The select-enable write with `eng_enable`=1 comes before the first start of a transaction. The write with `eng_enable`=0 comes after its last byte and before `done`. No start happens while chip select is high.
- R3: For each byte, `eng_tx_vld` loads the byte first. `eng_start` is then pulsed only while `eng_ready` is 1. The response is taken only after ready has returned.
- R4: Operation code 0 (data read) sends 0x03, then the address bytes [23:16], [15:8], [7:0], then `len` filler bytes of 0x00. The four header responses are discarded. The `len` filler responses are emitted in order.
- R5: Operation code 1 (identification read) sends 0x9F and three fillers, and emits all three responses. `len` is ignored.
- R6: Operation code 2 (unique-ID read) sends 0x4B and twelve fillers. The first four responses are discarded and the last eight are emitted.
- R7: Operation code 3 (status read) sends 0x05 and `len` fillers, and emits each filler response.
- R8: Operation code 4 (write enable) sends only 0x06 inside its own chip-select frame and emits nothing.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. No start pulse occurs while a byte is pending.
- R10: Between the release of chip select and its next assertion, at least `GAP_CYC` (default 2) cycles pass.
- R11: A data read with `len`=0 sends the opcode and three address bytes, then ends with `done` and emits no byte.
- R12: Operation codes 5 to 7 give `done` and `err` together with no engine activity and no output byte. `err` is 0 on every other `done`.
- R13: `req_ready` is 0 from acceptance until `done` has been given.
- R14: `done` is a single-cycle pulse that follows the chip-select release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 3 | Operation code (0 read, 1 ident, 2 unique ID, 3 status, 4 write enable) |
| req_addr | input | 24 | Flash byte address for data read |
| req_len | input | 16 | Bytes to read (data read and status read) |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished, one cycle |
| err | output | 1 | Unknown operation, valid with done |
| eng_enable | output | 1 | Select level for engine (1 = chip select low) |
| eng_enable_vld | output | 1 | Writes eng_enable into the engine |
| eng_tx_data | output | 8 | Byte to transmit |
| eng_tx_vld | output | 1 | Loads eng_tx_data into the engine |
| eng_start | output | 1 | Starts one byte exchange |
| eng_ready | input | 1 | Engine idle, last exchange complete |
| eng_rx_data | input | 8 | Byte received in the last exchange |

## Verification
The properties assume that the engine keeps `eng_ready` high while idle, drops it only because of a start pulse, and ignores transmit loads while busy. The bench engine model behaves this way. It lowers ready on the edge that takes a start and raises it a fixed number of cycles later with a response that depends on the byte's position in the frame. `out_ready` is driven either constantly high or from a pseudo-random pattern, so that the hold and no-start-while-pending properties are exercised. Requests are only offered while the sequencer is idle.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_IDENT  = 3'd1,
    OP_UID    = 3'd2,
    OP_STATUS = 3'd3,
    OP_WREN   = 3'd4
  } seq_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_LOAD, S_CHK, S_GO, S_ARM,
    S_WAIT, S_EMIT, S_DESEL, S_GAP, S_DONE
  } seq_state_e;

  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_IDENT  = 8'h9F;
  localparam logic [7:0] CMD_UID    = 8'h4B;
  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] FILL_BYTE  = 8'h00;
endpackage

// File: rtl/spi_seq_decode.sv
module spi_seq_decode
  import spi_seq_pkg::*;
(
  input  logic [2:0] op,
  output logic       legal,
  output logic [7:0] cmd,
  output logic [2:0] hdr_n,
  output logic [3:0] skip_n,
  output logic [3:0] fixed_n,
  output logic       use_len
);
  always_comb begin
    legal   = 1'b1;
    cmd     = CMD_WREN;
    hdr_n   = 3'd1;
    skip_n  = 4'd0;
    fixed_n = 4'd0;
    use_len = 1'b0;
    case (op)
      OP_READ:   begin cmd = CMD_READ;   hdr_n = 3'd4; use_len = 1'b1; end
      OP_IDENT:  begin cmd = CMD_IDENT;  fixed_n = 4'd3; end
      OP_UID:    begin cmd = CMD_UID;    skip_n = 4'd4; fixed_n = 4'd8; end
      OP_STATUS: begin cmd = CMD_STATUS; use_len = 1'b1; end
      OP_WREN:   begin cmd = CMD_WREN; end
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_seq_txmux.sv
module spi_seq_txmux
  import spi_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 17
) (
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        hdr_n,
  output logic [7:0]        tx_byte
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [7:0] abyte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_ab
    assign abyte[g] = addr[ADDR_W-1-8*g -: 8];
  end

  always_comb begin
    tx_byte = FILL_BYTE;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == CNT_W'(k + 1) && idx < CNT_W'(hdr_n)) tx_byte = abyte[k];
    end
    if (idx == '0) tx_byte = cmd;
  end
endmodule

// File: rtl/spi_seq_gap.sv
module spi_seq_gap #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);
  localparam int GW = $clog2(GAP_CYC + 1);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (arm)            cnt <= GW'(GAP_CYC - 1);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !arm;
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic              err,
  output logic              eng_enable,
  output logic              eng_enable_vld,
  output logic [7:0]        eng_tx_data,
  output logic              eng_tx_vld,
  output logic              eng_start,
  input  logic              eng_ready,
  input  logic [7:0]        eng_rx_data
);
  localparam int CNT_W = LEN_W + 1;

  seq_state_e        st;
  logic [7:0]        cmd_q, rx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        hdr_q;
  logic [CNT_W-1:0]  first_q, total_q, idx_q;
  logic              err_q;

  logic       d_legal, d_use_len;
  logic [7:0] d_cmd;
  logic [2:0] d_hdr;
  logic [3:0] d_skip, d_fixed;
  logic       gap_arm, gap_expired;
  logic       is_data, is_last;

  spi_seq_decode u_dec (
    .op(req_op), .legal(d_legal), .cmd(d_cmd), .hdr_n(d_hdr),
    .skip_n(d_skip), .fixed_n(d_fixed), .use_len(d_use_len)
  );

  spi_seq_txmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mux (
    .idx(idx_q), .cmd(cmd_q), .addr(addr_q), .hdr_n(hdr_q), .tx_byte(eng_tx_data)
  );

  spi_seq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .arm(gap_arm), .expired(gap_expired)
  );

  assign is_data = (idx_q >= first_q);
  assign is_last = ((idx_q + CNT_W'(1)) == total_q);

  assign req_ready      = (st == S_IDLE);
  assign eng_enable_vld = (st == S_SEL) || (st == S_DESEL);
  assign eng_enable     = (st == S_SEL);
  assign eng_tx_vld     = (st == S_LOAD);
  assign eng_start      = (st == S_GO);
  assign out_valid      = (st == S_EMIT);
  assign out_data       = rx_q;
  assign done           = (st == S_DONE);
  assign err            = (st == S_DONE) && err_q;
  assign gap_arm        = (st == S_DESEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      rx_q    <= '0;
      addr_q  <= '0;
      hdr_q   <= '0;
      first_q <= '0;
      total_q <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cmd_q   <= d_cmd;
          addr_q  <= req_addr;
          hdr_q   <= d_hdr;
          first_q <= CNT_W'(d_hdr) + CNT_W'(d_skip);
          total_q <= CNT_W'(d_hdr) + CNT_W'(d_skip) +
                     (d_use_len ? CNT_W'(req_len) : CNT_W'(d_fixed));
          idx_q   <= '0;
          err_q   <= !d_legal;
          st      <= d_legal ? S_SEL : S_DONE;
        end
        S_SEL:  st <= S_LOAD;
        S_LOAD: st <= S_CHK;
        S_CHK:  if (eng_ready) st <= S_GO;
        S_GO:   st <= S_ARM;
        S_ARM:  st <= S_WAIT;
        S_WAIT: if (eng_ready) begin
          rx_q <= eng_rx_data;
          if (is_data)      st <= S_EMIT;
          else if (is_last) st <= S_DESEL;
          else begin
            idx_q <= idx_q + CNT_W'(1);
            st    <= S_LOAD;
          end
        end
        S_EMIT: if (out_ready) begin
          if (is_last) st <= S_DESEL;
          else begin
            idx_q <= idx_q + CNT_W'(1);
            st    <= S_LOAD;
          end
        end
        S_DESEL: st <= S_GAP;
        S_GAP:   if (gap_expired) st <= S_DONE;
        S_DONE: begin
          err_q <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk #(
  parameter int GAP_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done,
  input logic       err,
  input logic       eng_enable,
  input logic       eng_enable_vld,
  input logic       eng_start,
  input logic       eng_ready
);
  logic [15:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rel <= 16'hFFFF;
    else if (eng_enable_vld && !eng_enable) since_rel <= '0;
    else if (since_rel != 16'hFFFF) since_rel <= since_rel + 16'd1;
  end

  a_r3_start_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_ready);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !eng_start);
  a_r10_select_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_enable_vld && eng_enable) |-> (since_rel >= 16'(GAP_CYC)));
  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r13_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_flash_seq spi_flash_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done), .err(err),
  .eng_enable(eng_enable), .eng_enable_vld(eng_enable_vld),
  .eng_start(eng_start), .eng_ready(eng_ready)
);

// File: tb/spi_flash_seq_bench.sv
`timescale 1ns/1ps
module spi_flash_seq_bench;
  localparam int BYTE_CYC = 5;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic out_valid, done, err;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic eng_enable, eng_enable_vld, eng_tx_vld, eng_start;
  logic [7:0] eng_tx_data;
  logic eng_ready;
  logic [7:0] eng_rx_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R4";
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] exp_out[$];
  logic [7:0] got_tx[$];
  int bad_start = 0;
  int min_gap = 1000;
  int hi_cnt = 0;
  bit seen_frame = 1'b0;
  int stalls = 0;

  always #5 clk = ~clk;

  spi_flash_seq u_spi_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .err(err), .eng_enable(eng_enable),
    .eng_enable_vld(eng_enable_vld), .eng_tx_data(eng_tx_data),
    .eng_tx_vld(eng_tx_vld), .eng_start(eng_start),
    .eng_ready(eng_ready), .eng_rx_data(eng_rx_data)
  );

  function automatic logic [7:0] resp(int p);
    return 8'(8'h3C ^ (p * 37));
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // byte engine model
  logic m_ss = 1'b1;
  logic m_rdy = 1'b1;
  logic [7:0] m_tx = '0;
  int m_cnt = 0;
  int m_pos = 0;
  assign eng_ready = m_rdy;
  assign eng_rx_data = resp(m_pos - 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ss <= 1'b1; m_rdy <= 1'b1; m_cnt <= 0; m_pos <= 0;
    end else begin
      if (eng_enable_vld) begin
        if (eng_enable && m_ss) begin
          if (seen_frame && hi_cnt < min_gap) min_gap = hi_cnt;
          seen_frame = 1'b1;
        end
        m_ss <= ~eng_enable;
      end
      if (m_ss) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
      if (eng_tx_vld && m_rdy) m_tx <= eng_tx_data;
      if (eng_start && m_rdy) begin
        m_rdy <= 1'b0;
        m_cnt <= BYTE_CYC;
        got_tx.push_back(m_tx);
        if (m_ss) bad_start++;
      end else if (!m_rdy) begin
        if (m_cnt == 0) begin
          m_rdy <= 1'b1;
          m_pos <= m_pos + 1;
        end else m_cnt <= m_cnt - 1;
      end
      if (m_ss && !(eng_enable_vld && eng_enable)) m_pos <= 0;
    end
  end

  // consumer, scoreboard monitor
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid === 1'b1, "R9", "valid held while stalled", out_valid, 1);
        chk(out_data === prev_data, "R9", "data held while stalled", out_data, prev_data);
        stalls++;
      end
      if (out_valid) chk(req_ready === 1'b0, "R13", "req_ready while busy", req_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0) chk(1'b0, cur_tag, "unexpected output byte", out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_out.pop_front();
          chk(out_data === e, cur_tag, "output byte", out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "R14", "watchdog expired", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // driver: compute expected bytes, issue request, compare
  task automatic run(input logic [2:0] op, input logic [23:0] addr,
                     input logic [15:0] len, input string tag);
    logic [7:0] etx[$];
    int first, total;
    bit legal;
    cur_tag = tag;
    legal = 1'b1;
    case (op)
      3'd0: begin etx = '{8'h03, addr[23:16], addr[15:8], addr[7:0]}; first = 4; total = 4 + len; end
      3'd1: begin etx = '{8'h9F}; first = 1; total = 4; end
      3'd2: begin etx = '{8'h4B}; first = 5; total = 13; end
      3'd3: begin etx = '{8'h05}; first = 1; total = 1 + len; end
      3'd4: begin etx = '{8'h06}; first = 1; total = 1; end
      default: begin legal = 1'b0; first = 0; total = 0; end
    endcase
    while (etx.size() < total) etx.push_back(8'h00);
    for (int p = first; p < total; p++) exp_out.push_back(resp(p));
    got_tx.delete();
    @(negedge clk);
    req_op = op; req_addr = addr; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0 || !legal, "R13", "req_ready after accept", req_ready, 0);
    while (done !== 1'b1) @(negedge clk);
    chk(err === !legal, legal ? tag : "R12", "err with done", err, !legal);
    chk(m_ss === 1'b1, "R2", "select released at done", m_ss, 1);
    chk(exp_out.size() == 0, tag, "bytes still expected at done", exp_out.size(), 0);
    chk(got_tx.size() == total, tag, "bytes sent", got_tx.size(), total);
    for (int i = 0; i < total && i < got_tx.size(); i++)
      chk(got_tx[i] === etx[i], tag, $sformatf("tx byte %0d", i), got_tx[i], etx[i]);
    @(negedge clk);
    chk(done === 1'b0, "R14", "done single cycle", done, 0);
    exp_out.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(done === 1'b0 && err === 1'b0, "R1", "done/err in reset", {done, err}, 0);
    chk(eng_enable_vld === 1'b0 && eng_tx_vld === 1'b0 && eng_start === 1'b0,
        "R1", "engine strobes in reset", {eng_enable_vld, eng_tx_vld, eng_start}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(3'd0, 24'h123456, 16'd5, "R4");
    run(3'd0, 24'hABCDEF, 16'd0, "R11");
    bp_mode = 1'b1;
    run(3'd1, 24'h0, 16'd9, "R5");
    run(3'd2, 24'h0, 16'd0, "R6");
    run(3'd3, 24'h0, 16'd2, "R7");
    run(3'd0, 24'h00FF01, 16'd7, "R4");
    bp_mode = 1'b0;
    run(3'd4, 24'h0, 16'd3, "R8");
    run(3'd6, 24'h0, 16'd4, "R12");
    run(3'd7, 24'h0, 16'd0, "R12");
    run(3'd3, 24'h0, 16'd1, "R7");

    chk(bad_start == 0, "R2", "starts with select high", bad_start, 0);
    chk(min_gap >= 2, "R10", "minimum select-high gap", min_gap, 2);
    chk(stalls > 0, "R9", "back-pressure exercised", stalls, 1);
    chk(m_ss === 1'b1, "R3", "engine idle select at end", m_ss, 1);
    finish_run();
  end
endmodule